// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how fast a fan turns by timing the gap between tachometer pulses. A slow reference enable (`osc_tick`, one clock wide) is divided by a programmable power-of-two prescaler. The divided ticks are counted between two consecutive rising edges of the tachometer input. Each rising edge copies the running count into the output register and starts a new count from zero. The result is a period: a fan that slows down or stalls produces a larger value.

The count stops at full scale. A further tick at full scale is an overflow, which means the fan has stalled or is far too slow. On overflow the output register is forced to full scale, and, if fault reporting is enabled, an active-low status bit drops while an active-high alert output rises in the same cycle. A later interval that finishes without overflow clears the fault. The tachometer input is asynchronous and goes through a two-flop synchronizer before edge detection.

Top module: `fan_tach_period`

## Requirements
- R1: Reset drives `period_cnt` to 0, `fault_n` to 1 and `fault_alert` to 0.
- R2: A rising edge on `tach_in` is synchronized by two flops and detected by one more. The count is latched on the third rising clock edge after the input changes.
- R3: The counter advances once per 2, 4, 8 or 16 `osc_tick` pulses for `div_sel` = 0, 1, 2 or 3. The counter never advances in a cycle without `osc_tick`.
- R4: On a detected rising edge, `period_cnt` takes the number of divided ticks counted since the previous edge, and the running count restarts at 0. A divided tick that coincides with the edge is not counted.
- R5: The running count saturates at 255. A divided tick while it is at 255 is an overflow: `period_cnt` becomes 255 at once, and the next edge also latches 255.
- R6: When an overflow occurs with `fault_en` = 1, `fault_n` goes to 0 and `fault_alert` goes to 1 on that clock edge. `fault_alert` is always the complement of `fault_n`.
- R7: While `fault_en` = 0, `fault_n` is 1 and `fault_alert` is 0 from the next clock edge on, and no overflow can set them.
- R8: An edge that ends an interval without overflow returns `fault_n` to 1. An edge that ends an overflowed interval leaves the fault set.
- R9: `period_cnt` changes only on a detected edge or on an overflow.
- R10: If `div_sel` is lowered below the prescaler's current position, the next `osc_tick` produces a divided tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle reference oscillator enable |
| tach_in | input | 1 | Asynchronous fan tachometer input |
| div_sel | input | 2 | Prescaler select: ratio 2 << div_sel |
| fault_en | input | 1 | Enables tach fault reporting |
| period_cnt | output | 8 | Latched period count |
| fault_n | output | 1 | Status bit, low on an enabled overflow |
| fault_alert | output | 1 | Immediate active-high fault alert |

## Verification
A rising edge on the tachometer reaches `period_cnt` on the third clock edge after the input changes. An overflow, and the fault bits that go with it, take effect on the clock edge at which the saturating divided tick occurs. Masking and recovery act one edge after their cause. The bench drives every input on the falling clock edge. A behavioural model updates on each rising edge from the inputs sampled there, and all three outputs are compared with the model on the next falling edge, so each result is checked in the cycle it is due. Directed checks on stall, masking and recovery compare the outputs with fixed values.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  // Number of synchronizer flops ahead of the edge detector.
  localparam int unsigned SYNC_DEPTH = 2;

  // All-ones value for a counter of the given width (saturation point).
  function automatic int unsigned full_scale(input int unsigned width);
    return (1 << width) - 1;
  endfunction
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int unsigned STAGES = fan_tach_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle delay.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PRE_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic [SEL_W-1:0] div_sel,
  output logic             cnt_tick
);
  localparam logic [PRE_W-1:0] ONES = '1;

  logic [PRE_W-1:0] pos;
  logic [PRE_W-1:0] lim;

  // Ratio is 2 << div_sel, so the last position is that minus one.
  always_comb lim = ONES >> (PRE_W - 1 - int'(div_sel));

  // ">=" lets a lowered ratio take effect on the next oscillator pulse.
  assign cnt_tick = osc_tick && (pos >= lim);

  always_ff @(posedge clk) begin
    if (rst)           pos <= '0;
    else if (osc_tick) pos <= cnt_tick ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/tach_period_ctr.sv
module tach_period_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             rise,
  input  logic             fault_en,
  output logic [CNT_W-1:0] period_cnt,
  output logic             fault_n,
  output logic             fault_alert
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(fan_tach_pkg::full_scale(CNT_W));

  logic [CNT_W-1:0] acc;
  logic             ovf_seen;
  logic             ovf_evt;
  logic             clear_evt;

  assign ovf_evt   = cnt_tick && !rise && (acc == FULL);
  assign clear_evt = rise && !ovf_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      ovf_seen   <= 1'b0;
      period_cnt <= '0;
    end else if (rise) begin
      period_cnt <= ovf_seen ? FULL : acc;
      acc        <= '0;
      ovf_seen   <= 1'b0;
    end else if (cnt_tick) begin
      if (acc == FULL) begin
        ovf_seen   <= 1'b1;
        period_cnt <= FULL;
      end else begin
        acc <= acc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !fault_en) begin
      fault_n     <= 1'b1;
      fault_alert <= 1'b0;
    end else if (ovf_evt) begin
      fault_n     <= 1'b0;
      fault_alert <= 1'b1;
    end else if (clear_evt) begin
      fault_n     <= 1'b1;
      fault_alert <= 1'b0;
    end
  end
endmodule

// File: rtl/fan_tach_period.sv
module fan_tach_period #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             tach_in,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             fault_en,
  output logic [CNT_W-1:0] period_cnt,
  output logic             fault_n,
  output logic             fault_alert
);
  logic rise_w;
  logic cnt_tick_w;

  tach_edge_sync #(.STAGES(fan_tach_pkg::SYNC_DEPTH)) u_edge (
    .clk (clk),
    .rst (rst),
    .din (tach_in),
    .rise(rise_w)
  );

  tach_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .osc_tick(osc_tick),
    .div_sel (div_sel),
    .cnt_tick(cnt_tick_w)
  );

  tach_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cnt_tick   (cnt_tick_w),
    .rise       (rise_w),
    .fault_en   (fault_en),
    .period_cnt (period_cnt),
    .fault_n    (fault_n),
    .fault_alert(fault_alert)
  );
endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             osc_tick,
  input logic             fault_en,
  input logic             rise,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] period_cnt,
  input logic             fault_n,
  input logic             fault_alert
);
  AST_RISE_GAP: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    cnt_tick |-> osc_tick); // R3
  AST_FALL_FULL: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> (&period_cnt)); // R5
  AST_ALERT_POL: assert property (@(posedge clk) disable iff (rst)
    fault_alert != fault_n); // R6
  AST_MASKED: assert property (@(posedge clk) disable iff (rst)
    !fault_en |=> fault_n); // R7
  AST_RECOVER: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> ($past(rise) || !$past(fault_en))); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rise && !cnt_tick) |=> $stable(period_cnt)); // R9
endmodule

bind fan_tach_period fan_tach_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .osc_tick   (osc_tick),
  .fault_en   (fault_en),
  .rise       (rise_w),
  .cnt_tick   (cnt_tick_w),
  .period_cnt (period_cnt),
  .fault_n    (fault_n),
  .fault_alert(fault_alert)
);

// File: tb/test_fan_tach_period.sv
`timescale 1ns/1ps
module test_fan_tach_period;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       tach_in = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       fault_en = 1'b1;
  logic [7:0] period_cnt;
  logic       fault_n;
  logic       fault_alert;

  always #4 clk = ~clk; // 125 MHz

  fan_tach_period i_fan_tach_period (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .tach_in(tach_in),
    .div_sel(div_sel), .fault_en(fault_en), .period_cnt(period_cnt),
    .fault_n(fault_n), .fault_alert(fault_alert)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int osc_gap = 1;
  int osc_cnt = 0;

  // Behavioural reference model.
  int hist[$];
  int ph, acc, per, okn;
  bit run;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int lim;
    bit rise, tick, ovf;
    int nokn;
    cycles++;
    if (rst) begin
      hist = '{0, 0, 0};
      ph = 0; acc = 0; per = 0; okn = 1; run = 0;
    end else begin
      lim  = (2 << div_sel) - 1;
      rise = (hist[1] == 1) && (hist[0] == 0);
      tick = osc_tick && (ph >= lim);
      if (osc_tick) ph = tick ? 0 : ph + 1;
      ovf  = tick && !rise && (acc == 255);
      if (!fault_en)         nokn = 1;
      else if (ovf)          nokn = 0;
      else if (rise && !run) nokn = 1;
      else                   nokn = okn;
      if (rise) begin
        per = run ? 255 : acc; acc = 0; run = 0;
      end else if (tick) begin
        if (acc == 255) begin run = 1; per = 255; end
        else acc++;
      end
      okn = nokn;
      hist = '{hist[1], hist[2], int'(tach_in)};
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      chk("R2 R3 R4 R9 R10 period", int'(period_cnt), per);
      chk("R6 R7 R8 fault_n", int'(fault_n), okn);
      chk("R6 fault_alert", int'(fault_alert), okn ^ 1);
    end
    // Reference oscillator enable, one cycle wide every osc_gap cycles.
    osc_cnt++;
    if (osc_cnt >= osc_gap) begin osc_cnt = 0; osc_tick = 1'b1; end
    else osc_tick = 1'b0;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    tach_in = 1'b1; wait_cyc(hi);
    tach_in = 1'b0; wait_cyc(lo);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(5);
    chk("R1 period", int'(period_cnt), 0);
    chk("R1 fault_n", int'(fault_n), 1);
    chk("R1 fault_alert", int'(fault_alert), 0);
    rst = 1'b0;
    wait_cyc(3);

    // R3 R4: several divisors and pulse spacings.
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      for (int p = 0; p < 4; p++) pulse(5 + p, 30 + 17 * p + 9 * d);
    end
    osc_gap = 3;
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      for (int p = 0; p < 3; p++) pulse(4, 60 + 23 * p);
    end
    // R10: lower the divisor mid-interval.
    osc_gap = 1; div_sel = 2'd3;
    tach_in = 1'b1; wait_cyc(4); tach_in = 1'b0; wait_cyc(13);
    div_sel = 2'd0; wait_cyc(20);
    pulse(3, 40);
    // R4: a tach edge right after every count.
    for (int p = 0; p < 10; p++) pulse(2, 2 + p);

    // R5 R6: stall the fan.
    div_sel = 2'd0; fault_en = 1'b1;
    pulse(3, 30);
    wait_cyc(560);
    chk("R5 stalled period", int'(period_cnt), 255);
    chk("R6 fault_n low", int'(fault_n), 0);
    chk("R6 alert high", int'(fault_alert), 1);

    // R7: mask, then unmask while still stalled.
    fault_en = 1'b0; wait_cyc(3);
    chk("R7 masked fault_n", int'(fault_n), 1);
    chk("R7 masked alert", int'(fault_alert), 0);
    fault_en = 1'b1; wait_cyc(4);
    chk("R6 refault", int'(fault_n), 0);

    // R8: edge ending the overflowed interval keeps the fault.
    pulse(3, 20);
    chk("R8 overflowed edge period", int'(period_cnt), 255);
    chk("R8 fault kept", int'(fault_n), 0);
    pulse(3, 20);
    chk("R8 fault cleared", int'(fault_n), 1);
    chk("R8 alert cleared", int'(fault_alert), 0);

    // R7: overflow while masked never flags.
    fault_en = 1'b0;
    wait_cyc(600);
    chk("R7 masked stall period", int'(period_cnt), 255);
    chk("R7 masked stall fault_n", int'(fault_n), 1);
    fault_en = 1'b1;
    pulse(3, 20);
    pulse(3, 20);

    // R1: reset mid-run.
    rst = 1'b1; wait_cyc(3);
    chk("R1 reset again period", int'(period_cnt), 0);
    chk("R1 reset again fault_n", int'(fault_n), 1);
    rst = 1'b0; wait_cyc(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule